// File: doc/BRIEF.md
# Trinomial Ring Bit-Parallel Multiplier

This block multiplies two elements of the polynomial ring GF(2)[x]/(x^N + x + 1) in a single combinational pass. Each operand is an N-bit coefficient vector in which bit i is the coefficient of x^i. The result is the product reduced modulo x^N + x + 1, again as an N-bit vector. Because the modulus has only three terms, the reduction stays shallow. When the modulus has a field of interest as one of its irreducible factors, the block can replace a slower multiplier built on a five-term modulus. One example is N = 99, whose ring holds a copy of the 91-bit field.

The product is formed in two parts. The first is a circulant (cyclic-convolution) product, which on its own equals multiplication modulo x^N + 1. Every row of that product already sums the partial products that would land above degree N-1. Those per-row high sums are kept and shifted up by one position. Adding them back supplies the extra x term of the modulus, so no separate reduction matrix is needed. The block holds no state, so the product follows the operands with no clock edge.

Top module: `trinomial_ring_mul`

## Requirements
- R1: `prod` equals `opnd_a`·`opnd_b` modulo x^N + x + 1 over GF(2), where bit i of each vector is the coefficient of x^i.
- R2: The block is purely combinational: `prod` reflects the present operands without any clock edge, and a later change of either operand is reflected at once.
- R3: If either operand is all zeros, `prod` is all zeros.
- R4: If either operand equals 1 (only bit 0 set), `prod` equals the other operand unchanged.
- R5: x^(N-1) times x (bit N-1 set in one operand, bit 1 in the other) gives 1 + x, that is, only bits 0 and 1 of `prod` set.
- R6: The product is commutative: swapping the operands leaves `prod` unchanged.
- R7: A high coefficient of degree k ≥ N is folded into result bits k-N and k-N+1. So x^(N-1)·x^(N-1) gives only bits N-2 and N-1 of `prod` set.
- R8: When the unreduced product has degree below N, `prod` equals the plain carry-less product with no reduction applied.
- R9: All-ones operands give the reduced product of the all-ones polynomial with itself.
- R10: R1 holds for every N ≥ 3, and in particular for N = 5, 29 and 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First operand; bit i is the coefficient of x^i |
| opnd_b | input | N | Second operand; bit i is the coefficient of x^i |
| prod | output | N | Product reduced modulo x^N + x + 1 |

## Verification
The assertions are immediate checks on combinational values. They assume that the operands are stable, known two-state vectors when those checks are evaluated. No clock or reset qualifies them. The bench drives operands only in the low phase of its clock and samples one time unit later, so each check sees settled values. The operand patterns that arm the identity, wrap and fold assertions (zero, one, x, x^(N-1)) are applied at every tested width, alongside random and all-ones vectors.

// File: rtl/trmul_pkg.sv
package trmul_pkg;

    // Default ring degree: x^99 + x + 1 holds a copy of the 91-bit field.
    localparam int unsigned TRMUL_DEFAULT_N = 99;

    // Column j of the first circulant row carries coefficient a[(N - j) mod N].
    function automatic int unsigned rev_index(input int unsigned j, input int unsigned n);
        return (n - j) % n;
    endfunction

endpackage

// File: rtl/trmul_row.sv
// One row of the circulant product, split into the terms that fall below
// degree N and those that wrap from above it.
module trmul_row #(
    parameter int unsigned N   = 99,
    parameter int unsigned ROW = 0
) (
    input  logic [N-1:0] rot_a,
    input  logic [N-1:0] opnd_b,
    output logic         circ_bit,
    output logic         high_bit
);
    // Columns above ROW come from partial products of degree N + ROW.
    localparam logic [N-1:0] HIGH_COLS = {N{1'b1}} << (ROW + 1);

    logic [N-1:0] terms;
    logic         low_bit;

    always_comb begin
        terms    = rot_a & opnd_b;
        high_bit = ^(terms & HIGH_COLS);
        low_bit  = ^(terms & ~HIGH_COLS);
        circ_bit = low_bit ^ high_bit;
    end
endmodule

// File: rtl/trmul_fold.sv
// Adds the high sums, moved up one place, onto the circulant product.
module trmul_fold #(
    parameter int unsigned N = 99
) (
    input  logic [N-1:0] circ_vec,
    input  logic [N-1:0] high_vec,
    output logic [N-1:0] prod
);
    always_comb begin
        prod = circ_vec ^ {high_vec[N-2:0], 1'b0};
    end

    // The last row has no column above it, so it never carries a high term.
    always_comb begin
        AST_LAST_ROW_NO_HIGH: assert (high_vec[N-1] == 1'b0); // R7
    end
endmodule

// File: rtl/trinomial_ring_mul.sv
module trinomial_ring_mul
    import trmul_pkg::*;
#(
    parameter int unsigned N = TRMUL_DEFAULT_N
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    output logic [N-1:0] prod
);
    localparam logic [N-1:0] ONE_V      = {{(N-1){1'b0}}, 1'b1};
    localparam logic [N-1:0] X_V        = {{(N-2){1'b0}}, 2'b10};
    localparam logic [N-1:0] ONE_PLUS_X = {{(N-2){1'b0}}, 2'b11};
    localparam logic [N-1:0] TOP_V      = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] FOLD_TOP   = {2'b11, {(N-2){1'b0}}};

    logic [N-1:0]   a_rev;
    logic [2*N-1:0] a_dbl;
    logic [N-1:0]   circ_vec;
    logic [N-1:0]   high_vec;

    for (genvar j = 0; j < N; j++) begin : g_rev
        assign a_rev[j] = opnd_a[rev_index(j, N)];
    end

    assign a_dbl = {a_rev, a_rev};

    // Row i sees the first row rotated left by i positions.
    for (genvar i = 0; i < N; i++) begin : g_row
        trmul_row #(.N(N), .ROW(i)) u_row (
            .rot_a    (a_dbl[N-i +: N]),
            .opnd_b   (opnd_b),
            .circ_bit (circ_vec[i]),
            .high_bit (high_vec[i])
        );
    end

    trmul_fold #(.N(N)) u_fold (
        .circ_vec (circ_vec),
        .high_vec (high_vec),
        .prod     (prod)
    );

    always_comb begin
        if (opnd_a == '0 || opnd_b == '0)
            AST_ZERO_OPERAND: assert (prod == '0); // R3
        if (opnd_a == ONE_V)
            AST_UNIT_A: assert (prod == opnd_b); // R4
        if (opnd_b == ONE_V)
            AST_UNIT_B: assert (prod == opnd_a); // R4
        if ((opnd_a == TOP_V && opnd_b == X_V) || (opnd_a == X_V && opnd_b == TOP_V))
            AST_WRAP_X: assert (prod == ONE_PLUS_X); // R5
        if (opnd_a == TOP_V && opnd_b == TOP_V)
            AST_FOLD_TOP: assert (prod == FOLD_TOP); // R7
        if (high_vec == '0)
            AST_NO_HIGH_NO_FOLD: assert (prod == circ_vec); // R8
    end
endmodule

// File: tb/trinomial_ring_mul_bench.sv
module trinomial_ring_mul_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [4:0]  a5  = '0, b5  = '0;
    logic [28:0] a29 = '0, b29 = '0;
    logic [98:0] a99 = '0, b99 = '0;
    logic [4:0]  p5;
    logic [28:0] p29;
    logic [98:0] p99;

    trinomial_ring_mul #(.N(5))  u_trinomial_ring_mul_n5  (.opnd_a(a5),  .opnd_b(b5),  .prod(p5));
    trinomial_ring_mul #(.N(29)) u_trinomial_ring_mul_n29 (.opnd_a(a29), .opnd_b(b29), .prod(p29));
    trinomial_ring_mul #(.N(99)) u_trinomial_ring_mul     (.opnd_a(a99), .opnd_b(b99), .prod(p99));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int sizes[3] = '{5, 29, 99};

    function automatic logic [98:0] wmask(input int n);
        return {99{1'b1}} >> (99 - n);
    endfunction

    function automatic logic [98:0] rnd(input int n);
        logic [127:0] w;
        w = {$urandom, $urandom, $urandom, $urandom};
        return w[98:0] & wmask(n);
    endfunction

    // Shift-and-add model modulo x^n + x + 1.
    function automatic logic [98:0] ref_mul(input logic [98:0] a, input logic [98:0] b, input int n);
        logic [98:0] acc, sh;
        logic        top;
        acc = '0;
        sh  = a;
        for (int i = 0; i < n; i++) begin
            if (b[i]) acc ^= sh;
            top = sh[n-1];
            sh  = (sh << 1) & wmask(n);
            if (top) sh ^= 99'd3;
        end
        return acc;
    endfunction

    // Plain carry-less product, valid when the degree stays below 99.
    function automatic logic [98:0] clmul(input logic [98:0] a, input logic [98:0] b);
        logic [98:0] acc;
        acc = '0;
        for (int i = 0; i < 99; i++)
            if (b[i]) acc ^= (a << i);
        return acc;
    endfunction

    task automatic set_ops(input int n, input logic [98:0] a, input logic [98:0] b);
        case (n)
            5:       begin a5  = a[4:0];  b5  = b[4:0];  end
            29:      begin a29 = a[28:0]; b29 = b[28:0]; end
            default: begin a99 = a;       b99 = b;       end
        endcase
    endtask

    function automatic logic [98:0] get_prod(input int n);
        case (n)
            5:       return {94'd0, p5};
            29:      return {70'd0, p29};
            default: return p99;
        endcase
    endfunction

    task automatic expect_eq(input string req, input int n, input logic [98:0] got, input logic [98:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s n=%0d got %h expected %h", req, n, got, exp);
        end
    endtask

    task automatic apply(input string req, input int n, input logic [98:0] a,
                         input logic [98:0] b, input logic [98:0] exp);
        @(negedge clk);
        set_ops(n, a, b);
        #1;
        expect_eq(req, n, get_prod(n), exp);
    endtask

    task automatic t_idle();
        #2;
        foreach (sizes[k]) expect_eq("R3 idle", sizes[k], get_prod(sizes[k]), '0);
    endtask

    task automatic t_zero();
        foreach (sizes[k]) begin
            int n = sizes[k];
            apply("R3 b zero", n, rnd(n), '0, '0);
            apply("R3 a zero", n, '0, rnd(n), '0);
        end
    endtask

    task automatic t_one();
        foreach (sizes[k]) begin
            int n = sizes[k];
            logic [98:0] v = rnd(n);
            apply("R4 one times v", n, 99'd1, v, v);
            apply("R4 v times one", n, v, 99'd1, v);
        end
    endtask

    task automatic t_wrap();
        foreach (sizes[k]) begin
            int n = sizes[k];
            logic [98:0] top = 99'd1 << (n - 1);
            apply("R5 top times x", n, top, 99'd2, 99'd3);
            apply("R5 x times top", n, 99'd2, top, 99'd3);
        end
    endtask

    task automatic t_fold();
        foreach (sizes[k]) begin
            int n = sizes[k];
            logic [98:0] top = 99'd1 << (n - 1);
            apply("R7 top squared", n, top, top, 99'd3 << (n - 2));
        end
    endtask

    task automatic t_low_degree();
        foreach (sizes[k]) begin
            int n = sizes[k];
            for (int t = 0; t < 4; t++) begin
                logic [98:0] m = wmask((n - 1) / 2 + 1);
                logic [98:0] a = rnd(n) & m;
                logic [98:0] b = rnd(n) & m;
                apply("R8 no reduction", n, a, b, clmul(a, b));
            end
        end
    endtask

    task automatic t_all_ones();
        foreach (sizes[k]) begin
            int n = sizes[k];
            apply("R9 all ones", n, wmask(n), wmask(n), ref_mul(wmask(n), wmask(n), n));
        end
    endtask

    task automatic t_random();
        foreach (sizes[k]) begin
            int n = sizes[k];
            for (int t = 0; t < 30; t++) begin
                logic [98:0] a = rnd(n);
                logic [98:0] b = rnd(n);
                logic [98:0] e = ref_mul(a, b, n);
                apply("R1/R10 random", n, a, b, e);
                apply("R6 swapped", n, b, a, e);
            end
        end
    endtask

    task automatic t_comb();
        foreach (sizes[k]) begin
            int n = sizes[k];
            logic [98:0] a  = rnd(n);
            logic [98:0] b1 = rnd(n);
            logic [98:0] b2 = rnd(n);
            @(negedge clk);
            set_ops(n, a, b1);
            #1;
            expect_eq("R2 first", n, get_prod(n), ref_mul(a, b1, n));
            set_ops(n, a, b2);
            #1;
            expect_eq("R2 change", n, get_prod(n), ref_mul(a, b2, n));
        end
    endtask

    initial begin
        t_idle();
        t_zero();
        t_one();
        t_wrap();
        t_fold();
        t_low_degree();
        t_all_ones();
        t_random();
        t_comb();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule